// File: doc/BRIEF.md
# JTAG Flash Lockout Recovery Controller

This block is a chip-level JTAG test access port with one extra public instruction. The instruction recovers a part whose on-chip flash has been secured. While the instruction is selected, a 7-bit data register takes over the divider that sets the flash timing clock. Bit 6 of that register enables a divide-by-8 prescaler, and bits 5:0 hold a divide field. When the TAP reaches Run-Test/Idle, the block checks the resulting frequency against the permitted window. If the frequency is in range, the block requests a full mass erase from the flash, which also erases the configuration area. When the flash acknowledges, the block sets a sticky flag that marks the unlock as pending.

The debug-read-block output is taken from the stored security word only while the system reset is asserted. After an erase, the part therefore stays locked until the next reset, when the flash reads back erased. The JTAG pins are sampled with the system clock, so the whole block runs in one clock domain.

Top module: `jtag_erase_unlock`

## Requirements
- R1: After reset the TAP is in Test-Logic-Reset with IDCODE selected. A 32-bit DR scan returns the parameter IDCODE_VAL, least significant bit first.
- R2: Capture-IR loads 4'b0001 into the instruction shift register. Opcode 4'b1111 (BYPASS) selects a 1-bit register that captures 0.
- R3: Opcode 4'b1011 selects a 7-bit divider register. Update-DR stores it, and Capture-DR reloads the stored value.
- R4: While opcode 4'b1011 is current, fm_div_o equals the stored register: bit 6 is the prescale enable, bits 5:0 the divide field. Otherwise fm_div_o equals norm_div_i.
- R5: ftick_o pulses once every (DIV+1) system clocks, or every 8*(DIV+1) clocks when the prescale bit is set.
- R6: Entering Run-Test/Idle with opcode 4'b1011 and a freshly updated register starts the erase. erase_req_o is a one-cycle pulse, and erase_done_i then sets unlock_pend_o, which stays set until reset. At most one erase runs per reset.
- R7: If SYS_HZ divided by the divisor lies outside FMIN_HZ..FMAX_HZ, the start sets cfg_err_o and issues no request. A new Update-DR clears cfg_err_o.
- R8: Test-Logic-Reset, reached by trst_n_i low or five TCLK cycles with TMS high, discards a loaded divider before its request is issued. A later Run-Test/Idle then starts no erase.
- R9: dbg_block_o is loaded from sec_word_i only during system reset. It is high unless the word is all ones, and it holds its value while reset is released, even after an erase completes.
- R10: A reset after a completed erase, with sec_word_i now all ones, clears dbg_block_o and unlock_pend_o.
- R11: tdo_o changes only after a falling TCLK edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous system reset |
| tck_i | input | 1 | JTAG test clock, sampled by clk |
| tms_i | input | 1 | JTAG mode select |
| tdi_i | input | 1 | JTAG serial data in |
| trst_n_i | input | 1 | Active-low JTAG reset |
| tdo_o | output | 1 | JTAG serial data out |
| sec_word_i | input | SEC_W | Security word read from flash |
| norm_div_i | input | 7 | Divider value used outside recovery |
| erase_done_i | input | 1 | Mass erase finished acknowledge |
| erase_req_o | output | 1 | One-cycle mass erase request |
| fm_div_o | output | 7 | Divider in effect (prescale, divide field) |
| ftick_o | output | 1 | Flash timing clock enable pulse |
| cfg_err_o | output | 1 | Divider out of permitted frequency range |
| unlock_pend_o | output | 1 | Erase complete, unlock at next reset |
| dbg_block_o | output | 1 | Blocks memory reads over debug/JTAG |

## Verification
The hardest situation to reach is an abort: the divider register has already been updated and the recovery is armed, but the TAP must leave for Test-Logic-Reset before it enters Run-Test/Idle. The stimulus finishes the DR scan with TMS high, so the TAP moves from Update-DR to Select-DR-Scan and not to idle. It then resets the TAP once with five TMS-high clocks and once with TRST low. Afterwards it reselects the recovery opcode and passes through idle, and it checks that no erase request appears.

// File: rtl/jeu_pkg.sv
package jeu_pkg;

    typedef enum logic [3:0] {
        S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR,
        S_UPDR, S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPIR
    } tap_state_e;

    typedef enum logic [1:0] {Q_IDLE, Q_WAIT, Q_DONE} seq_state_e;

    localparam logic [3:0] OP_IDCODE = 4'b0010;
    localparam logic [3:0] OP_BYPASS = 4'b1111;
    localparam logic [3:0] OP_RECOV  = 4'b1011;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            S_TLR:   return m ? S_TLR   : S_RTI;
            S_RTI:   return m ? S_SELDR : S_RTI;
            S_SELDR: return m ? S_SELIR : S_CAPDR;
            S_CAPDR: return m ? S_EX1DR : S_SHDR;
            S_SHDR:  return m ? S_EX1DR : S_SHDR;
            S_EX1DR: return m ? S_UPDR  : S_PADR;
            S_PADR:  return m ? S_EX2DR : S_PADR;
            S_EX2DR: return m ? S_UPDR  : S_SHDR;
            S_UPDR:  return m ? S_SELDR : S_RTI;
            S_SELIR: return m ? S_TLR   : S_CAPIR;
            S_CAPIR: return m ? S_EX1IR : S_SHIR;
            S_SHIR:  return m ? S_EX1IR : S_SHIR;
            S_EX1IR: return m ? S_UPIR  : S_PAIR;
            S_PAIR:  return m ? S_EX2IR : S_PAIR;
            S_EX2IR: return m ? S_UPIR  : S_SHIR;
            default: return m ? S_SELDR : S_RTI;
        endcase
    endfunction

endpackage

// File: rtl/jeu_tap.sv
module jeu_tap
    import jeu_pkg::*;
#(
    parameter int          IR_W       = 4,
    parameter int          ID_W       = 32,
    parameter int          DIV_W      = 7,
    parameter logic [31:0] IDCODE_VAL = 32'h0F3A_6C1B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tap_rst,
    input  logic             rise,
    input  logic             fall,
    input  logic             tms,
    input  logic             tdi,
    output logic             tdo_o,
    output logic [DIV_W-1:0] div_o,
    output logic             recov_o,
    output logic             rti_o,
    output logic             tlr_o,
    output logic             upd_o
);
    typedef struct packed {
        tap_state_e        st;
        logic [IR_W-1:0]   ir;
        logic [IR_W-1:0]   ir_sr;
        logic [ID_W-1:0]   dr_sr;
        logic [DIV_W-1:0]  div;
        logic              upd;
        logic              tdo;
    } tap_t;

    tap_t q, d;
    logic recov_q, idc_q;

    assign recov_q = (q.ir == OP_RECOV);
    assign idc_q   = (q.ir == OP_IDCODE);

    always_comb begin
        d     = q;
        d.upd = 1'b0;
        if (tap_rst) begin
            d.st  = S_TLR;
            d.ir  = OP_IDCODE;
            d.div = '0;
        end else begin
            if (q.st == S_TLR) begin
                d.ir  = OP_IDCODE;
                d.div = '0;
            end
            if (rise) begin
                case (q.st)
                    S_CAPIR: d.ir_sr = IR_W'(1);
                    S_SHIR:  d.ir_sr = {tdi, q.ir_sr[IR_W-1:1]};
                    S_UPIR:  d.ir    = q.ir_sr;
                    S_CAPDR: begin
                        if (idc_q)        d.dr_sr = IDCODE_VAL[ID_W-1:0];
                        else if (recov_q) d.dr_sr = ID_W'(q.div);
                        else              d.dr_sr = '0;
                    end
                    S_SHDR: begin
                        d.dr_sr = q.dr_sr >> 1;
                        if (idc_q)        d.dr_sr[ID_W-1]  = tdi;
                        else if (recov_q) d.dr_sr[DIV_W-1] = tdi;
                        else              d.dr_sr[0]       = tdi;
                    end
                    S_UPDR: begin
                        if (recov_q) begin
                            d.div = q.dr_sr[DIV_W-1:0];
                            d.upd = 1'b1;
                        end
                    end
                    default: ;
                endcase
                d.st = tap_next(q.st, tms);
            end
            if (fall) begin
                if (q.st == S_SHIR)      d.tdo = q.ir_sr[0];
                else if (q.st == S_SHDR) d.tdo = q.dr_sr[0];
                else                     d.tdo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= S_TLR;
            q.ir  <= OP_IDCODE;
        end else begin
            q <= d;
        end
    end

    assign tdo_o   = q.tdo;
    assign div_o   = q.div;
    assign recov_o = recov_q;
    assign rti_o   = (q.st == S_RTI);
    assign tlr_o   = (q.st == S_TLR);
    assign upd_o   = q.upd;
endmodule

// File: rtl/jeu_fdiv.sv
module jeu_fdiv #(
    parameter int unsigned SYS_HZ  = 8_000_000,
    parameter int unsigned FMIN_HZ = 150_000,
    parameter int unsigned FMAX_HZ = 200_000,
    parameter int          DIV_W   = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o,
    output logic             ok_o
);
    localparam int FLD_W = DIV_W - 1;
    localparam int CNT_W = FLD_W + 4;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             tick;
    } fd_t;

    fd_t q, d;
    logic [CNT_W-1:0] span;
    logic [63:0]      lo_lim, hi_lim;

    always_comb begin
        span = CNT_W'(div_i[FLD_W-1:0]) + CNT_W'(1);
        if (div_i[DIV_W-1]) span = span << 3;
        lo_lim = 64'(FMIN_HZ) * 64'(span);
        hi_lim = 64'(FMAX_HZ) * 64'(span);
        ok_o   = (64'(SYS_HZ) >= lo_lim) && (64'(SYS_HZ) <= hi_lim);

        d = q;
        if (q.cnt >= span - CNT_W'(1)) begin
            d.cnt  = '0;
            d.tick = 1'b1;
        end else begin
            d.cnt  = q.cnt + CNT_W'(1);
            d.tick = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tick_o = q.tick;
endmodule

// File: rtl/jeu_seq.sv
module jeu_seq
    import jeu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic upd_i,
    input  logic rti_i,
    input  logic tlr_i,
    input  logic recov_i,
    input  logic ok_i,
    input  logic done_i,
    output logic req_o,
    output logic err_o,
    output logic pend_o
);
    typedef struct packed {
        seq_state_e st;
        logic       armed;
        logic       req;
        logic       err;
        logic       pend;
    } sq_t;

    sq_t q, d;

    always_comb begin
        d     = q;
        d.req = 1'b0;
        if (tlr_i) d.armed = 1'b0;
        if (upd_i) begin
            d.armed = 1'b1;
            d.err   = 1'b0;
        end
        case (q.st)
            Q_IDLE: begin
                if (q.armed && rti_i && recov_i && !tlr_i) begin
                    d.armed = 1'b0;
                    if (ok_i) begin
                        d.req = 1'b1;
                        d.st  = Q_WAIT;
                    end else begin
                        d.err = 1'b1;
                    end
                end
            end
            Q_WAIT: begin
                d.armed = 1'b0;
                if (done_i) begin
                    d.pend = 1'b1;
                    d.st   = Q_DONE;
                end
            end
            default: d.armed = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= Q_IDLE;
        end else begin
            q <= d;
        end
    end

    assign req_o  = q.req;
    assign err_o  = q.err;
    assign pend_o = q.pend;
endmodule

// File: rtl/jtag_erase_unlock.sv
module jtag_erase_unlock #(
    parameter int unsigned SYS_HZ     = 8_000_000,
    parameter int unsigned FMIN_HZ    = 150_000,
    parameter int unsigned FMAX_HZ    = 200_000,
    parameter int          SEC_W      = 16,
    parameter int          DIV_W      = 7,
    parameter logic [31:0] IDCODE_VAL = 32'h0F3A_6C1B
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tck_i,
    input  logic             tms_i,
    input  logic             tdi_i,
    input  logic             trst_n_i,
    output logic             tdo_o,
    input  logic [SEC_W-1:0] sec_word_i,
    input  logic [DIV_W-1:0] norm_div_i,
    input  logic             erase_done_i,
    output logic             erase_req_o,
    output logic [DIV_W-1:0] fm_div_o,
    output logic             ftick_o,
    output logic             cfg_err_o,
    output logic             unlock_pend_o,
    output logic             dbg_block_o
);
    typedef struct packed {
        logic [2:0] tck;
        logic [1:0] tms;
        logic [1:0] tdi;
        logic [1:0] trst;
        logic       blk;
    } sy_t;

    sy_t q, d;
    logic tck_rise, tck_fall, tap_rst;
    logic [DIV_W-1:0] tap_div;
    logic recov, in_rti, in_tlr, dr_upd, div_ok;

    always_comb begin
        d      = q;
        d.tck  = {q.tck[1:0], tck_i};
        d.tms  = {q.tms[0], tms_i};
        d.tdi  = {q.tdi[0], tdi_i};
        d.trst = {q.trst[0], trst_n_i};
        if (!rst_n) begin
            d     = '0;
            d.blk = (sec_word_i != '1);
        end
    end

    always_ff @(posedge clk) q <= d;

    assign tck_rise = q.tck[1] & ~q.tck[2];
    assign tck_fall = ~q.tck[1] & q.tck[2];
    assign tap_rst  = ~rst_n | ~q.trst[1];

    jeu_tap #(
        .IR_W(4), .ID_W(32), .DIV_W(DIV_W), .IDCODE_VAL(IDCODE_VAL)
    ) tap_i (
        .clk(clk), .rst_n(rst_n), .tap_rst(tap_rst),
        .rise(tck_rise), .fall(tck_fall), .tms(q.tms[1]), .tdi(q.tdi[1]),
        .tdo_o(tdo_o), .div_o(tap_div), .recov_o(recov),
        .rti_o(in_rti), .tlr_o(in_tlr), .upd_o(dr_upd)
    );

    assign fm_div_o = recov ? tap_div : norm_div_i;

    jeu_fdiv #(
        .SYS_HZ(SYS_HZ), .FMIN_HZ(FMIN_HZ), .FMAX_HZ(FMAX_HZ), .DIV_W(DIV_W)
    ) fdiv_i (
        .clk(clk), .rst_n(rst_n), .div_i(fm_div_o),
        .tick_o(ftick_o), .ok_o(div_ok)
    );

    jeu_seq seq_i (
        .clk(clk), .rst_n(rst_n), .upd_i(dr_upd), .rti_i(in_rti),
        .tlr_i(in_tlr), .recov_i(recov), .ok_i(div_ok),
        .done_i(erase_done_i), .req_o(erase_req_o),
        .err_o(cfg_err_o), .pend_o(unlock_pend_o)
    );

    assign dbg_block_o = q.blk;
endmodule

// File: rtl/jeu_chk.sv
module jeu_chk (
    input logic clk,
    input logic rst_n,
    input logic tck_fall,
    input logic tdo,
    input logic req,
    input logic done,
    input logic pend,
    input logic err,
    input logic div_ok,
    input logic blk
);
    a_r11_tdo_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(tck_fall)) |-> $stable(tdo));

    a_r6_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);

    a_r6_pend_from_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(done));

    a_r6_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> pend);

    a_r7_req_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> div_ok);

    a_r7_err_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !req);

    a_r9_block_held: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(blk));
endmodule

bind jtag_erase_unlock jeu_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tck_fall(tck_fall), .tdo(tdo_o),
    .req(erase_req_o), .done(erase_done_i), .pend(unlock_pend_o),
    .err(cfg_err_o), .div_ok(div_ok), .blk(dbg_block_o)
);

// File: tb/jtag_erase_unlock_tb_top.sv
module jtag_erase_unlock_tb_top;
    localparam logic [31:0] IDC = 32'h0F3A_6C1B;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        tck = 0, tms = 1, tdi = 0, trst_n = 1;
    logic        tdo;
    logic [15:0] sec_word = 16'h5A5A;
    logic [6:0]  norm_div = {1'b1, 6'd2};
    logic        erase_done = 0;
    logic        erase_req, ftick, cfg_err, pend, blk;
    logic [6:0]  fm_div;

    int checks = 0, errors = 0, req_cnt = 0;

    always #2.5 clk = ~clk;

    jtag_erase_unlock dut_i (
        .clk(clk), .rst_n(rst_n), .tck_i(tck), .tms_i(tms), .tdi_i(tdi),
        .trst_n_i(trst_n), .tdo_o(tdo), .sec_word_i(sec_word),
        .norm_div_i(norm_div), .erase_done_i(erase_done),
        .erase_req_o(erase_req), .fm_div_o(fm_div), .ftick_o(ftick),
        .cfg_err_o(cfg_err), .unlock_pend_o(pend), .dbg_block_o(blk)
    );

    // behavioural flash: acknowledges an erase and reads back erased afterwards
    always @(negedge clk) begin
        if (erase_req) begin
            req_cnt++;
            repeat (20) @(negedge clk);
            erase_done = 1;
            sec_word   = 16'hFFFF;
            @(negedge clk);
            erase_done = 0;
        end
    end

    task automatic chk(input string req, input logic ok, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tcyc(input logic m, input logic b, output logic o);
        tms = m; tdi = b;
        repeat (6) @(negedge clk);
        o = tdo;
        tck = 1;
        repeat (6) @(negedge clk);
        tck = 0;
    endtask

    task automatic shift_ir(input logic [3:0] v, output logic [3:0] cap);
        logic o;
        tcyc(1, 0, o); tcyc(1, 0, o); tcyc(0, 0, o); tcyc(0, 0, o);
        for (int i = 0; i < 4; i++) begin
            tcyc(i == 3, v[i], o);
            cap[i] = o;
        end
        tcyc(1, 0, o); tcyc(0, 0, o);
    endtask

    task automatic shift_dr(input logic [31:0] v, input int n, input logic to_idle,
                            output logic [31:0] got);
        logic o;
        got = '0;
        tcyc(1, 0, o); tcyc(0, 0, o); tcyc(0, 0, o);
        for (int i = 0; i < n; i++) begin
            tcyc(i == n - 1, v[i], o);
            got[i] = o;
        end
        tcyc(1, 0, o); tcyc(!to_idle, 0, o);
    endtask

    task automatic do_reset();
        rst_n = 0; tms = 1; tck = 0;
        repeat (10) @(negedge clk);
        rst_n = 1;
        repeat (4) @(negedge clk);
    endtask

    task automatic period(output int p);
        p = 0;
        while (!ftick) @(negedge clk);
        @(negedge clk);
        p = 1;
        while (!ftick) begin
            @(negedge clk);
            p++;
        end
    endtask

    task automatic t_reset_state();
        logic o;
        do_reset();
        chk("R9 blocked after secured reset", blk === 1'b1, blk, 1);
        chk("R10 pending clear after reset", pend === 1'b0, pend, 0);
        chk("R4 normal divider at reset", fm_div === norm_div, fm_div, norm_div);
        tcyc(0, 0, o);
    endtask

    task automatic t_idcode();
        logic [31:0] g;
        shift_dr(32'h0, 32, 1, g);
        // R1 and R11: bits are taken just before each rising TCLK edge
        chk("R1 IDCODE scan", g === IDC, g, IDC);
    endtask

    task automatic t_bypass();
        logic [3:0] c;
        logic [31:0] g;
        shift_ir(4'b1111, c);
        chk("R2 IR capture pattern", c === 4'b0001, c, 1);
        shift_dr(32'h1, 2, 1, g);
        chk("R2 bypass single-bit delay", g[1:0] === 2'b10, g[1:0], 2);
    endtask

    task automatic t_range_err();
        logic [3:0] c;
        logic [31:0] g;
        shift_ir(4'b1011, c);
        shift_dr(32'd53, 7, 1, g);
        repeat (10) @(negedge clk);
        chk("R7 slow divider flagged", cfg_err === 1'b1, cfg_err, 1);
        chk("R7 no request on bad divider", req_cnt == 0, req_cnt, 0);
        chk("R4 override active", fm_div === 7'd53, fm_div, 53);
        shift_dr({25'h0, 7'h40}, 7, 1, g);
        repeat (10) @(negedge clk);
        chk("R3 capture returns stored value", g[6:0] === 7'd53, g[6:0], 53);
        chk("R7 fast divider flagged", cfg_err === 1'b1 && req_cnt == 0, cfg_err, 1);
    endtask

    task automatic t_tick();
        int p;
        period(p);
        chk("R5 prescaled period", p == 8, p, 8);
    endtask

    task automatic t_abort();
        logic [3:0] c;
        logic [31:0] g;
        logic o;
        shift_dr(32'd39, 7, 0, g);
        for (int i = 0; i < 5; i++) tcyc(1, 0, o);
        tcyc(0, 0, o);
        chk("R4 normal divider after TMS reset", fm_div === norm_div, fm_div, norm_div);
        begin
            int p;
            period(p);
            chk("R5 normal divider period", p == 24, p, 24);
        end
        shift_ir(4'b1011, c);
        repeat (10) @(negedge clk);
        chk("R8 TMS reset discards load", req_cnt == 0, req_cnt, 0);
        chk("R7 update cleared error", cfg_err === 1'b0, cfg_err, 0);
        shift_dr(32'd39, 7, 0, g);
        trst_n = 0;
        repeat (10) @(negedge clk);
        trst_n = 1;
        repeat (4) @(negedge clk);
        tcyc(0, 0, o);
        shift_ir(4'b1011, c);
        repeat (10) @(negedge clk);
        chk("R8 TRST discards load", req_cnt == 0, req_cnt, 0);
    endtask

    task automatic t_erase();
        logic [31:0] g;
        logic o;
        shift_dr(32'd39, 7, 1, g);
        repeat (40) @(negedge clk);
        chk("R6 one erase request", req_cnt == 1, req_cnt, 1);
        chk("R6 pending after done", pend === 1'b1, pend, 1);
        chk("R9 still blocked before reset", blk === 1'b1, blk, 1);
        chk("R4 recovery divider in effect", fm_div === 7'd39, fm_div, 39);
        for (int i = 0; i < 4; i++) tcyc(0, 0, o);
        shift_dr(32'd39, 7, 1, g);
        repeat (40) @(negedge clk);
        chk("R6 no second erase", req_cnt == 1 && pend === 1'b1, req_cnt, 1);
    endtask

    task automatic t_unlock();
        do_reset();
        chk("R10 unblocked after erased reset", blk === 1'b0, blk, 0);
        chk("R10 pending cleared", pend === 1'b0, pend, 0);
        sec_word = 16'h1234;
        repeat (5) @(negedge clk);
        chk("R9 ignores word outside reset", blk === 1'b0, blk, 0);
        do_reset();
        chk("R9 relocked by secured reset", blk === 1'b1, blk, 1);
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset_state();
        t_idcode();
        t_bypass();
        t_range_err();
        t_tick();
        t_abort();
        t_erase();
        t_unlock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule